// File: doc/BRIEF.md
# Clock-Ratio Peripheral Bridge

This block connects a master running on a fast clock to slaves that advance only once every RATIO fast cycles. The slow domain is not a separate clock. It is a free-running enable pulse that the bridge generates and exports, so the whole block stays synchronous. The master raises a request and keeps the request, address, direction and write data steady while the bridge holds it in wait. The bridge starts the slave access at the start of a slow period. It samples the slave's ready on each enable pulse, so a slave can stretch any access to N slow periods. The bridge then signals completion. For a read, it returns the captured data one fast cycle later.

Timing follows closed-form rules in N and RATIO. A write issued on the first fast cycle of a slow period takes N·RATIO fast cycles. A write issued one cycle later must first wait for the next period, which makes the worst case (N+1)·RATIO−1. Every read costs one more fast cycle, which registers the slave data into the fast domain. At completion the bridge also reports the cycle count of the transfer, so that each access can be checked against these bounds.

Top module: `perclk_bridge`

## Requirements
- R1: After reset the phase counter is at the start of a slow period, no completion or wait is signalled, the slave select is low and the first enable pulse comes RATIO−1 cycles after reset is released.
- R2: The enable pulse `p_en` is high on exactly one fast cycle in every RATIO, on the last fast cycle of each slow period, whatever the traffic.
- R3: The slave select `p_sel` rises only on the first fast cycle of a slow period. It stays high until the enable cycle on which the slave reports ready. A request that arrives in a later phase drives no slave select until the next period begins.
- R4: A write completes (`m_done` high, combinationally with `p_ready`) on the enable cycle where the slave is selected and ready. A write started on the first fast cycle of a period has a latency of N·RATIO fast cycles.
- R5: A read captures `p_rdata` on the enable cycle where the slave is ready and presents it on `m_rdata` together with `m_done` in the next fast cycle. An aligned read has a latency of N·RATIO+1.
- R6: For a request that starts at phase p (0 ≤ p < RATIO), the latency is ((RATIO−p) mod RATIO) + N·RATIO, plus 1 for a read. The worst case is (N+1)·RATIO−1 for a write and (N+1)·RATIO for a read.
- R7: When a new request follows in the cycle after a completion, completions are spaced N·RATIO cycles apart for writes and (N+1)·RATIO cycles apart for reads.
- R8: At completion `m_lat` equals the number of fast cycles from the first cycle of the request through the completion cycle, both counted.
- R9: `m_wait` equals a held request without completion. With RATIO = 1 and N = 1 a write takes 1 cycle and a read takes 2 cycles.
- R10: While selected, the slave receives the master's address, direction and write data unchanged. A completed write leaves exactly that address and data at the slave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req | input | 1 | Master request, held until completion |
| m_write | input | 1 | 1 = write, 0 = read |
| m_addr | input | ADDR_W | Transfer address |
| m_wdata | input | DATA_W | Write data |
| m_wait | output | 1 | Master must hold the request |
| m_done | output | 1 | Transfer completes this cycle |
| m_rdata | output | DATA_W | Read data, valid with m_done on reads |
| m_lat | output | LAT_W | Transfer latency in fast cycles, valid with m_done |
| p_en | output | 1 | Slow-domain enable pulse |
| p_sel | output | 1 | Slave select |
| p_write | output | 1 | Direction to slave |
| p_addr | output | ADDR_W | Address to slave |
| p_wdata | output | DATA_W | Write data to slave |
| p_ready | input | 1 | Slave ready, sampled on p_en cycles |
| p_rdata | input | DATA_W | Slave read data |

## Verification
Single writes and reads are started at every phase of the slow period with slave lengths of 1, 2, 3 and 5 periods. This separates the aligned latency from the misaligned latency and the write path from the read path. Chains of back-to-back requests show whether the completion spacing matches the write rule and the read rule. A write ends on the last phase and a read ends on the first phase, so the next request lands at a different alignment in each case. A second instance with a ratio of one exposes the single-cycle write and two-cycle read. A cycle-accurate reference compares the enable, select, wait and completion signals on every cycle.

// File: rtl/pbb_pkg.sv
`timescale 1ns/1ps
package pbb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACCESS  = 2'd1,
        ST_CAPTURE = 2'd2
    } pbb_state_e;

endpackage

// File: rtl/pbb_tick_gen.sv
`timescale 1ns/1ps
module pbb_tick_gen #(
    parameter int RATIO = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick,
    output logic phase_zero
);
    localparam int PW = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

    typedef struct packed {
        logic [PW-1:0] phase;
    } tick_regs_t;

    tick_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (r_q.phase == LAST) begin
            r_d.phase = '0;
        end else begin
            r_d.phase = r_q.phase + 1'b1;
        end
        tick       = (r_q.phase == LAST);
        phase_zero = (r_q.phase == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    generate
        if (RATIO > 1) begin : g_gap
            p_tick_isolated_r2: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
            p_zero_follows_tick_r2: assert property (@(posedge clk) disable iff (rst)
                tick |=> phase_zero);
        end
    endgenerate

endmodule

// File: rtl/pbb_lat_count.sv
`timescale 1ns/1ps
module pbb_lat_count #(
    parameter int LAT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             done,
    output logic [LAT_W-1:0] lat
);
    localparam logic [LAT_W-1:0] TOP = '1;

    typedef struct packed {
        logic [LAT_W-1:0] elapsed;
    } lat_regs_t;

    lat_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (done || !req) begin
            r_d.elapsed = '0;
        end else if (r_q.elapsed != TOP - 1'b1) begin
            r_d.elapsed = r_q.elapsed + 1'b1;
        end
        lat = r_q.elapsed + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    p_lat_restart_r8: assert property (@(posedge clk) disable iff (rst)
        (done && req) |=> (lat == LAT_W'(1)));
    p_lat_grows_r8: assert property (@(posedge clk) disable iff (rst)
        (req && !done && lat < TOP - 1'b1) |=> (lat == $past(lat) + 1'b1));

endmodule

// File: rtl/pbb_xfer_seq.sv
`timescale 1ns/1ps
module pbb_xfer_seq
    import pbb_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              phase_zero,
    input  logic              m_req,
    input  logic              m_write,
    input  logic              p_ready,
    input  logic [DATA_W-1:0] p_rdata,
    output logic              p_sel,
    output logic              m_done,
    output logic [DATA_W-1:0] m_rdata
);
    typedef struct packed {
        pbb_state_e        state;
        logic [DATA_W-1:0] rdata;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic      active;

    always_comb begin
        r_d    = r_q;
        p_sel  = 1'b0;
        m_done = 1'b0;
        active = (r_q.state == ST_ACCESS) ||
                 ((r_q.state == ST_IDLE) && m_req && phase_zero);
        unique case (r_q.state)
            ST_CAPTURE: begin
                m_done    = 1'b1;
                r_d.state = ST_IDLE;
            end
            default: begin
                if (active) begin
                    p_sel = 1'b1;
                    if (tick && p_ready) begin
                        if (m_write) begin
                            m_done    = 1'b1;
                            r_d.state = ST_IDLE;
                        end else begin
                            r_d.rdata = p_rdata;
                            r_d.state = ST_CAPTURE;
                        end
                    end else begin
                        r_d.state = ST_ACCESS;
                    end
                end
            end
        endcase
        m_rdata = r_q.rdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state <= ST_IDLE;
            r_q.rdata <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    p_launch_on_period_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(p_sel) |-> ($past(tick) || $past(rst)));
    p_write_ends_on_tick_r4: assert property (@(posedge clk) disable iff (rst)
        (m_done && m_write) |-> (tick && p_sel && p_ready));
    p_read_ends_after_tick_r5: assert property (@(posedge clk) disable iff (rst)
        (m_done && !m_write) |-> ($past(tick) && $past(p_sel) && $past(p_ready)));
    p_read_data_held_r5: assert property (@(posedge clk) disable iff (rst)
        (m_done && !m_write) |-> (m_rdata == $past(p_rdata)));
    p_capture_single_r5: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_CAPTURE) |=> (r_q.state != ST_CAPTURE));

endmodule

// File: rtl/perclk_bridge.sv
`timescale 1ns/1ps
module perclk_bridge #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int RATIO  = 4,
    parameter int LAT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              m_req,
    input  logic              m_write,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic [DATA_W-1:0] m_wdata,
    output logic              m_wait,
    output logic              m_done,
    output logic [DATA_W-1:0] m_rdata,
    output logic [LAT_W-1:0]  m_lat,
    output logic              p_en,
    output logic              p_sel,
    output logic              p_write,
    output logic [ADDR_W-1:0] p_addr,
    output logic [DATA_W-1:0] p_wdata,
    input  logic              p_ready,
    input  logic [DATA_W-1:0] p_rdata
);
    logic tick;
    logic phase_zero;

    pbb_tick_gen #(
        .RATIO(RATIO)
    ) u_tick (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .phase_zero (phase_zero)
    );

    pbb_xfer_seq #(
        .DATA_W(DATA_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .phase_zero (phase_zero),
        .m_req      (m_req),
        .m_write    (m_write),
        .p_ready    (p_ready),
        .p_rdata    (p_rdata),
        .p_sel      (p_sel),
        .m_done     (m_done),
        .m_rdata    (m_rdata)
    );

    pbb_lat_count #(
        .LAT_W(LAT_W)
    ) u_lat (
        .clk  (clk),
        .rst  (rst),
        .req  (m_req),
        .done (m_done),
        .lat  (m_lat)
    );

    always_comb begin
        p_en    = tick;
        p_write = m_write;
        p_addr  = m_addr;
        p_wdata = m_wdata;
        m_wait  = m_req && !m_done;
    end

    p_wait_held_r9: assert property (@(posedge clk) disable iff (rst)
        m_wait |=> m_req);
    p_sel_needs_req_r3: assert property (@(posedge clk) disable iff (rst)
        p_sel |-> m_req);
    p_done_has_lat_r8: assert property (@(posedge clk) disable iff (rst)
        m_done |-> (m_lat >= LAT_W'(1)));

endmodule

// File: tb/sim_perclk_lane.sv
`timescale 1ns/1ps
module sim_perclk_lane #(
    parameter int R = 3
) (
    input  logic clk,
    input  logic rst,
    output int   n_vec,
    output int   n_bad,
    output logic fin
);
    localparam int AW = 8;
    localparam int DW = 16;

    logic          m_req, m_write, m_wait, m_done, p_en, p_sel, p_write, p_ready;
    logic [AW-1:0] m_addr, p_addr;
    logic [DW-1:0] m_wdata, m_rdata, p_wdata, p_rdata;
    logic [15:0]   m_lat;

    perclk_bridge #(.ADDR_W(AW), .DATA_W(DW), .RATIO(R), .LAT_W(16)) u0 (
        .clk(clk), .rst(rst), .m_req(m_req), .m_write(m_write), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_wait(m_wait), .m_done(m_done), .m_rdata(m_rdata),
        .m_lat(m_lat), .p_en(p_en), .p_sel(p_sel), .p_write(p_write),
        .p_addr(p_addr), .p_wdata(p_wdata), .p_ready(p_ready), .p_rdata(p_rdata)
    );

    int cyc;
    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    // behavioural slave: ready after s_n sampled periods
    int            s_cnt, s_n;
    logic [AW-1:0] s_last_a;
    logic [DW-1:0] s_last_d;
    assign p_ready = p_sel && (s_cnt == s_n - 1);
    assign p_rdata = {p_addr, ~p_addr};
    always @(posedge clk) begin
        if (rst) begin
            s_cnt <= 0; s_last_a <= '0; s_last_d <= '0;
        end else if (p_en && p_sel) begin
            if (p_ready) begin
                s_cnt <= 0;
                if (p_write) begin s_last_a <= p_addr; s_last_d <= p_wdata; end
            end else begin
                s_cnt <= s_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s (ratio %0d) %s: actual %0d expected %0d", tag, R, what, act, expv);
        end
    endtask

    // R2: enable pattern compared every cycle
    always @(negedge clk) begin
        if (!rst) begin
            #1;
            chk(p_en == ((cyc % R) == R - 1), "R2", "p_en", int'(p_en), int'((cyc % R) == R - 1));
        end
    end

    task automatic xfer(input bit wr, input int a, input int d, input int n,
                        input bit hold, output int done_cyc);
        int  s, a0, ex;
        bit  over;
        m_req = 1'b1; m_write = wr; m_addr = AW'(a); m_wdata = DW'(d); s_n = n;
        s  = cyc;
        a0 = s + ((R - (s % R)) % R);
        ex = a0 + n * R - 1 + (wr ? 0 : 1);
        over = 1'b0;
        while (!over) begin
            #1;
            chk(m_done == (cyc == ex), wr ? "R4/R6" : "R5/R6", "m_done", int'(m_done), int'(cyc == ex));
            chk(p_sel == ((cyc >= a0) && (wr ? (cyc <= ex) : (cyc < ex))), "R3", "p_sel",
                int'(p_sel), int'((cyc >= a0) && (wr ? (cyc <= ex) : (cyc < ex))));
            chk(m_wait == (cyc != ex), "R9", "m_wait", int'(m_wait), int'(cyc != ex));
            if (p_sel) begin
                chk(p_addr == AW'(a) && p_write == wr, "R10", "p_addr", int'(p_addr), a);
            end
            if (m_done || cyc >= ex) begin
                over = 1'b1;
                chk(int'(m_lat) == ex - s + 1, "R8", "m_lat", int'(m_lat), ex - s + 1);
                if (!wr) chk(m_rdata == {AW'(a), ~AW'(a)}, "R5", "m_rdata",
                             int'(m_rdata), int'({AW'(a), ~AW'(a)}));
                if (R == 1 && n == 1) chk(ex - s + 1 == (wr ? 1 : 2), "R9", "unit latency",
                                          ex - s + 1, wr ? 1 : 2);
            end
            done_cyc = cyc;
            @(negedge clk);
        end
        if (!hold) m_req = 1'b0;
        if (wr) begin
            chk(s_last_a == AW'(a), "R10", "slave addr", int'(s_last_a), a);
            chk(s_last_d == DW'(d), "R10", "slave data", int'(s_last_d), d);
        end
    endtask

    task automatic go_phase(input int ph);
        while ((cyc % R) != ph) @(negedge clk);
    endtask

    initial begin
        int dc, prev;
        n_vec = 0; n_bad = 0; fin = 1'b0;
        m_req = 1'b0; m_write = 1'b0; m_addr = '0; m_wdata = '0; s_n = 1;
        wait (rst == 1'b0);
        @(negedge clk);
        #1;
        chk(!m_done && !m_wait && !p_sel, "R1", "idle after reset",
            int'({m_done, m_wait, p_sel}), 0);
        chk(cyc == 1 && p_en == (R <= 2), "R1", "first pulse", int'(p_en), int'(R <= 2));
        @(negedge clk);
        // single transfers at every phase, both directions
        for (int n = 1; n <= 3; n++) begin
            for (int ph = 0; ph < R; ph++) begin
                for (int w = 1; w >= 0; w--) begin
                    go_phase(ph);
                    xfer(w[0], 16 * n + ph + w, 1000 * n + 7 * ph + w, n, 1'b0, dc);
                    @(negedge clk);
                end
            end
        end
        go_phase(R > 1 ? 1 : 0);
        xfer(1'b0, 8'h3c, 0, 5, 1'b0, dc);
        @(negedge clk);
        // R7: back-to-back writes then reads
        go_phase(0);
        xfer(1'b1, 8'h40, 16'h1111, 2, 1'b1, prev);
        for (int k = 1; k < 3; k++) begin
            xfer(1'b1, 8'h40 + k, 16'h1111 + k, 2, 1'b1, dc);
            chk(dc - prev == 2 * R, "R7", "write spacing", dc - prev, 2 * R);
            prev = dc;
        end
        xfer(1'b0, 8'h50, 0, 2, 1'b1, prev);
        for (int k = 1; k < 3; k++) begin
            xfer(1'b0, 8'h50 + k, 0, 2, k == 2 ? 1'b0 : 1'b1, dc);
            chk(dc - prev == 3 * R, "R7", "read spacing", dc - prev, 3 * R);
            prev = dc;
        end
        repeat (2) @(negedge clk);
        fin = 1'b1;
    end

endmodule

// File: tb/sim_perclk_bridge.sv
`timescale 1ns/1ps
module sim_perclk_bridge;
    logic clk = 1'b0;
    logic rst = 1'b1;
    int   v0, b0, v1, b1;
    logic f0, f1;
    int   extra_bad;

    always #2 clk = ~clk;

    sim_perclk_lane #(.R(4)) u0 (.clk(clk), .rst(rst), .n_vec(v0), .n_bad(b0), .fin(f0));
    sim_perclk_lane #(.R(1)) u1 (.clk(clk), .rst(rst), .n_vec(v1), .n_bad(b1), .fin(f1));

    initial begin
        extra_bad = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 100000 && !(f0 && f1); i++) @(negedge clk);
        if (!(f0 && f1)) begin
            extra_bad = 1;
            $display("FAIL watchdog: actual unfinished expected finished");
        end
        $display("== %0d vectors applied, %0d miscompares ==", v0 + v1 + extra_bad, b0 + b1 + extra_bad);
        $finish;
    end
endmodule